// File: doc/BRIEF.md
# Tagged Granule Memory

This block is an on-chip memory that keeps a single validity bit beside every 16-byte (128-bit) data granule. The bit marks a granule as a genuine capability rather than arbitrary data. It lives in a separate sideband array that no data access can address. A single request port carries both reads and writes. A capability flag on each request chooses between capability accesses, which move the full granule together with its tag, and ordinary data accesses, which never expose or set the tag.

Any ordinary write clears the granule's tag, whatever its byte mask. So a data path can never produce a tagged granule, and only a capability write can set the bit. Capability accesses must be granule-aligned. A misaligned one is refused with an error response and changes nothing. Every accepted request gets exactly one response, registered one cycle after acceptance.

Top module: `tagged_granule_mem`

## Requirements
- R1: After reset every tag is 0, and `rsp_valid` is low until the first request is accepted.
- R2: `req_ready` is high in every cycle after the first cycle out of reset. Each accepted request (`req_valid & req_ready` at a rising edge) raises `rsp_valid` for exactly the following cycle, and only then.
- R3: An aligned capability write (`req_write=1`, `req_cap=1`) stores all 16 bytes of `req_wdata` whatever `req_bmask` is, and sets the granule's tag to `req_wtag`.
- R4: An aligned capability read returns the stored 128-bit granule on `rsp_rdata` and its tag on `rsp_rtag`, in the cycle after acceptance.
- R5: A data write (`req_write=1`, `req_cap=0`) updates byte lane i (bits 8i+7..8i) only when `req_bmask[i]` is 1, and leaves the other lanes unchanged.
- R6: Every accepted data write sets the addressed granule's tag to 0, including a write with a single mask bit or an all-zero mask.
- R7: A data read returns the granule on `rsp_rdata` with `rsp_rtag` forced to 0, and does not change the stored tag.
- R8: A capability access whose `req_addr[3:0]` is non-zero returns `rsp_err=1` with `rsp_rdata=0` and `rsp_rtag=0`, and changes neither data nor tag.
- R9: Data accesses ignore `req_addr[3:0]`; the granule index is always `req_addr[ADDR_W-1:4]`.
- R10: The response to any write carries `rsp_rdata=0` and `rsp_rtag=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_addr | input | ADDR_W | Byte address; bits [3:0] are the offset within the granule |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cap | input | 1 | 1 = capability access, 0 = data access |
| req_bmask | input | 16 | Byte-lane enables for data writes |
| req_wdata | input | 128 | Write data |
| req_wtag | input | 1 | Tag value for capability writes |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 128 | Read data (0 for writes and errors) |
| rsp_rtag | output | 1 | Tag (capability reads only, else 0) |
| rsp_err | output | 1 | Misaligned capability access refused |

## Verification
A stale or wrongly written tag cannot be seen through data reads. It shows up only on the next aligned capability read of that granule, one cycle after that read is accepted. The sweeps therefore follow every data write, zero-mask write and refused misaligned access with a capability read of each affected granule. A byte lane enabled by mistake shows as a wrong byte in that same read-back. A response that is missing or doubled is visible on `rsp_valid` in the cycle right after acceptance.

// File: rtl/tgm_pkg.sv
package tgm_pkg;
  localparam int GRAN_BYTES = 16;
  localparam int GRAN_BITS  = GRAN_BYTES * 8;
  localparam int OFF_W      = $clog2(GRAN_BYTES);

  typedef struct packed {
    logic                  rd_en;
    logic                  tag_we;
    logic                  tag_val;
    logic                  err;
    logic                  show_tag;
    logic [GRAN_BYTES-1:0] lane_we;
  } tgm_ctl_t;
endpackage

// File: rtl/tgm_req_decode.sv
module tgm_req_decode
  import tgm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                  fire,
  input  logic                  is_write,
  input  logic                  is_cap,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [GRAN_BYTES-1:0] bmask,
  input  logic                  wtag,
  output tgm_ctl_t              ctl
);
  logic misaligned;
  logic go;

  assign misaligned = is_cap && (addr[OFF_W-1:0] != '0);
  assign go         = fire && !misaligned;

  always_comb begin
    ctl          = '0;
    ctl.err      = fire && misaligned;
    ctl.rd_en    = go && !is_write;
    ctl.show_tag = go && !is_write && is_cap;
    ctl.tag_we   = go && is_write;
    ctl.tag_val  = is_cap ? wtag : 1'b0;
    if (go && is_write)
      ctl.lane_we = is_cap ? {GRAN_BYTES{1'b1}} : bmask;
  end
endmodule

// File: rtl/tgm_byte_ram.sv
module tgm_byte_ram #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic [7:0]       wd,
  input  logic             re,
  output logic [7:0]       rd
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
    if (re) rd <= mem[idx];
  end
endmodule

// File: rtl/tgm_tag_store.sv
module tgm_tag_store #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic             wval,
  input  logic             re,
  output logic             rd
);
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      rd     <= 1'b0;
    end else begin
      if (we) bits_q[idx] <= wval;
      if (re) rd <= bits_q[idx];
    end
  end
endmodule

// File: rtl/tagged_granule_mem.sv
module tagged_granule_mem
  import tgm_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + tgm_pkg::OFF_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic                           req_write,
  input  logic                           req_cap,
  input  logic [tgm_pkg::GRAN_BYTES-1:0] req_bmask,
  input  logic [tgm_pkg::GRAN_BITS-1:0]  req_wdata,
  input  logic                           req_wtag,
  output logic                           rsp_valid,
  output logic [tgm_pkg::GRAN_BITS-1:0]  rsp_rdata,
  output logic                           rsp_rtag,
  output logic                           rsp_err
);
  logic                 ready_q;
  logic                 fire;
  tgm_ctl_t             ctl;
  logic [IDX_W-1:0]     idx;
  logic [GRAN_BITS-1:0] ram_rd;
  logic                 tag_rd;
  logic                 valid_q, err_q, show_data_q, show_tag_q;

  assign fire = req_valid && ready_q;
  assign idx  = req_addr[ADDR_W-1:OFF_W];

  tgm_req_decode #(.ADDR_W(ADDR_W)) u_dec (
    .fire     (fire),
    .is_write (req_write),
    .is_cap   (req_cap),
    .addr     (req_addr),
    .bmask    (req_bmask),
    .wtag     (req_wtag),
    .ctl      (ctl)
  );

  for (genvar g = 0; g < GRAN_BYTES; g++) begin : g_lane
    tgm_byte_ram #(.DEPTH(DEPTH)) u_ram (
      .clk (clk),
      .idx (idx),
      .we  (ctl.lane_we[g]),
      .wd  (req_wdata[8*g +: 8]),
      .re  (ctl.rd_en),
      .rd  (ram_rd[8*g +: 8])
    );
  end

  tgm_tag_store #(.DEPTH(DEPTH)) u_tags (
    .clk  (clk),
    .rst  (rst),
    .idx  (idx),
    .we   (ctl.tag_we),
    .wval (ctl.tag_val),
    .re   (ctl.rd_en),
    .rd   (tag_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q     <= 1'b0;
      valid_q     <= 1'b0;
      err_q       <= 1'b0;
      show_data_q <= 1'b0;
      show_tag_q  <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      valid_q     <= fire;
      err_q       <= ctl.err;
      show_data_q <= ctl.rd_en;
      show_tag_q  <= ctl.show_tag;
    end
  end

  assign req_ready = ready_q;
  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = show_data_q ? ram_rd : '0;
  assign rsp_rtag  = show_tag_q && tag_rd;
endmodule

// File: rtl/tgm_checker.sv
module tgm_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_cap,
  input logic              rsp_valid,
  input logic [127:0]      rsp_rdata,
  input logic              rsp_rtag,
  input logic              rsp_err
);
  logic fire, bad_cap;
  assign fire    = req_valid && req_ready;
  assign bad_cap = req_cap && (req_addr[3:0] != 4'h0);

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !rsp_valid); // R2
  AST_MISALIGNED_CAP_ERR: assert property (@(posedge clk) disable iff (rst)
    (fire && bad_cap) |=> (rsp_err && rsp_rdata == '0 && !rsp_rtag)); // R8
  AST_NO_ERR_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
    (fire && !bad_cap) |=> !rsp_err); // R8
  AST_DATA_READ_HIDES_TAG: assert property (@(posedge clk) disable iff (rst)
    (fire && !req_cap) |=> !rsp_rtag); // R7
  AST_WRITE_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fire && req_write) |=> (rsp_rdata == '0 && !rsp_rtag)); // R10
endmodule

bind tagged_granule_mem tgm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_write (req_write),
  .req_cap   (req_cap),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_rtag  (rsp_rtag),
  .rsp_err   (rsp_err)
);

// File: tb/tagged_granule_mem_test.sv
`timescale 1ns/1ps
module tagged_granule_mem_test;
  localparam int DEPTH = 16;
  localparam int AW    = 8;
  localparam real CLK_NS = 5.0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [AW-1:0] req_addr = '0;
  logic         req_write = 1'b0;
  logic         req_cap = 1'b0;
  logic [15:0]  req_bmask = '0;
  logic [127:0] req_wdata = '0;
  logic         req_wtag = 1'b0;
  logic         rsp_valid;
  logic [127:0] rsp_rdata;
  logic         rsp_rtag;
  logic         rsp_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [127:0] m_data [DEPTH];
  logic         m_tag  [DEPTH];

  logic         got_v, got_t, got_e, rdy;
  logic [127:0] got_d;

  always #(CLK_NS/2) clk = ~clk;

  tagged_granule_mem #(.DEPTH(DEPTH)) uut (.*);

  function automatic logic [127:0] pat(int i, int salt);
    logic [31:0] a;
    a = 32'(i) * 32'h9E37_79B1 + 32'(salt) * 32'h85EB_CA6B;
    return {a, ~a, a ^ 32'h5A5A_A5A5, a + 32'(salt)};
  endfunction

  task automatic chk(string rq, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic c, input logic [AW-1:0] a,
                      input logic [15:0] m, input logic [127:0] d, input logic t);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_cap = c; req_addr = a;
    req_bmask = m; req_wdata = d; req_wtag = t;
    rdy = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
    got_v = rsp_valid; got_d = rsp_rdata; got_t = rsp_rtag; got_e = rsp_err;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 rsp_valid after reset", 128'(rsp_valid), 128'(0));
    @(negedge clk);
    chk("R2 ready after reset", 128'(req_ready), 128'(1));

    // R1: every tag reads 0 after reset
    for (int i = 0; i < DEPTH; i++) begin
      xfer(0, 1, AW'(i << 4), 16'h0, '0, 0);
      chk("R2 response valid", 128'(got_v & rdy), 128'(1));
      chk("R1 reset tag", 128'(got_t), 128'(0));
    end

    // R3: capability writes ignore mask, set tag; R10 quiet response
    for (int i = 0; i < DEPTH; i++) begin
      m_data[i] = pat(i, 1);
      m_tag[i]  = (i % 3) != 0;
      xfer(1, 1, AW'(i << 4), 16'h0, m_data[i], m_tag[i]);
      chk("R10 write rdata", got_d, '0);
      chk("R10 write rtag", 128'(got_t), 128'(0));
    end
    // R4: capability read-back of data and tag
    for (int i = 0; i < DEPTH; i++) begin
      xfer(0, 1, AW'(i << 4), 16'hFFFF, '0, 0);
      chk("R3 R4 cap data", got_d, m_data[i]);
      chk("R3 R4 cap tag", 128'(got_t), 128'(m_tag[i]));
    end
    // R7 R9: data reads at any offset hide the tag
    for (int i = 0; i < DEPTH; i++) begin
      xfer(0, 0, AW'((i << 4) | i), 16'h0, '0, 0);
      chk("R9 data read offset", got_d, m_data[i]);
      chk("R7 data read rtag", 128'(got_t), 128'(0));
    end
    for (int i = 0; i < DEPTH; i++) begin
      xfer(0, 1, AW'(i << 4), 16'h0, '0, 0);
      chk("R7 tag kept after data read", 128'(got_t), 128'(m_tag[i]));
    end
    // R5 R6 R9: masked data writes, including zero mask
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0]  m;
      logic [127:0] d;
      m = (i == 0) ? 16'h0 : ((16'h1 << i) | (16'h8000 >> i));
      d = pat(i, 7);
      for (int b = 0; b < 16; b++)
        if (m[b]) m_data[i][8*b +: 8] = d[8*b +: 8];
      m_tag[i] = 1'b0;
      xfer(1, 0, AW'((i << 4) | (15 - i)), m, d, 1'b1);
      chk("R10 data write rdata", got_d, '0);
    end
    for (int i = 0; i < DEPTH; i++) begin
      xfer(0, 1, AW'(i << 4), 16'h0, '0, 0);
      chk("R5 masked lanes", got_d, m_data[i]);
      chk("R6 tag cleared by data write", 128'(got_t), 128'(0));
    end
    // R8: misaligned capability accesses are refused
    m_data[3] = pat(3, 11); m_tag[3] = 1'b1;
    xfer(1, 1, AW'(3 << 4), 16'h0, m_data[3], 1'b1);
    for (int o = 1; o < 16; o++) begin
      xfer(1, 1, AW'((3 << 4) | o), 16'hFFFF, pat(o, 99), 1'b0);
      chk("R8 misaligned write err", 128'(got_e), 128'(1));
      xfer(0, 1, AW'((3 << 4) | o), 16'h0, '0, 0);
      chk("R8 misaligned read err", 128'(got_e), 128'(1));
      chk("R8 misaligned read data", got_d, '0);
    end
    xfer(0, 1, AW'(3 << 4), 16'h0, '0, 0);
    chk("R8 data unchanged", got_d, m_data[3]);
    chk("R8 tag unchanged", 128'(got_t), 128'(1));
    chk("R8 aligned no err", 128'(got_e), 128'(0));
    // R6: one-byte data write clears tag
    m_data[3][7:0] = 8'hC3; m_tag[3] = 1'b0;
    xfer(1, 0, AW'(3 << 4), 16'h0001, {120'h0, 8'hC3}, 1'b1);
    xfer(0, 1, AW'(3 << 4), 16'h0, '0, 0);
    chk("R6 one-byte write tag", 128'(got_t), 128'(0));
    chk("R5 one-byte write data", got_d, m_data[3]);
    @(negedge clk);
    chk("R2 no response when idle", 128'(rsp_valid), 128'(0));
    finish_run();
  end
endmodule